// File: doc/BRIEF.md
# Protected Selector:Offset Address Translator

This block turns a selector:offset reference into a 24-bit physical address. It holds a small table of descriptors. Each descriptor gives a block start address, a block length, a writable flag and a present flag. Part of the selector picks a table entry. The block adds the 16-bit offset to that entry's base. Before it releases the address, it checks the access against the entry: the entry must be present, the offset must lie inside the block, and a write needs a writable block.

A request is accepted in any cycle in which `req_valid` is high. The response is registered and appears one cycle later. It carries either the physical address with cause 00, or a zeroed address with a 2-bit fault cause. Software fills the table through a load port that writes one descriptor per clock. A request made in the same cycle as a load sees the table as it stood before the load.

Top module: `prot_xlate`

## Requirements
- R1: After reset, every table entry reads as not present, and the outputs are `rsp_valid`=0, `rsp_cause`=00 and `rsp_addr`=0.
- R2: `rsp_valid` is high in exactly the cycles that follow a cycle with `req_valid` high. When it is low, `rsp_cause` is 00 and `rsp_addr` is 0.
- R3: An access that passes every check responds with cause 00 and `rsp_addr` = base + offset. For example, base 0x164400 with offset 0x2400 gives 0x166800.
- R4: An access to an entry whose present flag is 0 responds with cause 01.
- R5: An offset greater than or equal to the entry's length responds with cause 10. With length 0x2400, offset 0x2400 faults and offset 0x23FF passes. With length 0, every offset faults.
- R6: A write (`req_write`=1) to an entry whose writable flag is 0 responds with cause 11. A read of the same entry does not fault for this reason.
- R7: When several checks fail, the reported cause follows a fixed priority: not-present first, then bounds, then write protection. Every faulting response drives `rsp_addr` to 0.
- R8: The table index is `req_sel[5:3]`. Selector bits [2:0] and [15:6] have no effect on the response.
- R9: A load (`ld_en`=1) writes the descriptor at `ld_idx` at the clock edge and leaves every other entry unchanged. A request in the same cycle as a load uses the old contents of that entry. A request in the next cycle uses the new contents.
- R10: The address sum wraps modulo 2^24. For example, base 0xFFFF00 with offset 0x0200 gives 0x000100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write one descriptor this cycle |
| ld_idx | input | 3 | Entry to write |
| ld_base | input | 24 | Block start address |
| ld_limit | input | 16 | Block length in bytes |
| ld_wr_ok | input | 1 | Block may be written |
| ld_present | input | 1 | Block is present |
| req_valid | input | 1 | Translation request |
| req_sel | input | 16 | Selector; bits [5:3] pick the entry |
| req_ofs | input | 16 | Offset into the block |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_cause | output | 2 | 00 ok, 01 not present, 10 out of bounds, 11 write to read-only |
| rsp_addr | output | 24 | Physical address, 0 on a fault |

## Verification
The load port and a translation request can fall in the same cycle and target the same entry. That is where an ordering error would show. The bench loads a descriptor while it asks for the same entry in that very cycle, and then asks again one cycle later. It expects the first response to reflect the old descriptor, for example a not-present fault, and the second to reflect the new one. The cycle-by-cycle reference model judges this by updating its own table only after it has computed the expected response of that cycle.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int PA_W  = 24;
  localparam int LEN_W = 16;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_ABSENT = 2'b01,
    CAUSE_RANGE  = 2'b10,
    CAUSE_RDONLY = 2'b11
  } cause_e;

  typedef struct packed {
    logic [PA_W-1:0]  base;
    logic [LEN_W-1:0] limit;
    logic             wr_ok;
    logic             present;
  } desc_t;

  // base + offset, wrapping at the top of the physical space
  function automatic logic [PA_W-1:0] phys_sum(input logic [PA_W-1:0] b,
                                               input logic [LEN_W-1:0] o);
    return b + PA_W'(o);
  endfunction

  // fault selection with fixed priority: absent, range, read-only
  function automatic cause_e pick_cause(input logic absent, input logic over,
                                        input logic wr_denied);
    if (absent)    return CAUSE_ABSENT;
    if (over)      return CAUSE_RANGE;
    if (wr_denied) return CAUSE_RDONLY;
    return CAUSE_NONE;
  endfunction
endpackage

// File: rtl/xlate_sel_decode.sv
module xlate_sel_decode #(
  parameter int SEL_W   = 16,
  parameter int IDX_LSB = 3,
  parameter int IDX_W   = 3
) (
  input  logic [SEL_W-1:0] sel,
  output logic [IDX_W-1:0] idx
);
  // low IDX_LSB bits and bits above the index field are dropped
  assign idx = IDX_W'(sel >> IDX_LSB);
endmodule

// File: rtl/xlate_desc_table.sv
module xlate_desc_table
  import xlate_pkg::*;
#(
  parameter int N_DESC = 8,
  localparam int IDX_W = $clog2(N_DESC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  desc_t            wr_desc,
  input  logic [IDX_W-1:0] rd_idx,
  output desc_t            rd_desc
);
  desc_t slot_q [N_DESC];

  for (genvar g = 0; g < N_DESC; g++) begin : g_slot
    desc_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               q <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))    q <= wr_desc;
    end
    assign slot_q[g] = q;
  end

  assign rd_desc = slot_q[rd_idx];
endmodule

// File: rtl/xlate_check.sv
module xlate_check
  import xlate_pkg::*;
(
  input  desc_t            d,
  input  logic [LEN_W-1:0] ofs,
  input  logic             wr,
  output cause_e           cause,
  output logic [PA_W-1:0]  addr,
  output logic             hit_present,
  output logic             hit_over,
  output logic             hit_rdonly
);
  assign hit_present = d.present;
  assign hit_over    = (ofs >= d.limit);
  assign hit_rdonly  = !d.wr_ok;
  assign cause       = pick_cause(!hit_present, hit_over, wr && hit_rdonly);
  assign addr        = phys_sum(d.base, ofs);
endmodule

// File: rtl/prot_xlate.sv
module prot_xlate
  import xlate_pkg::*;
#(
  parameter int SEL_W   = 16,
  parameter int IDX_LSB = 3,
  parameter int N_DESC  = 8,
  localparam int IDX_W  = $clog2(N_DESC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [PA_W-1:0]  ld_base,
  input  logic [LEN_W-1:0] ld_limit,
  input  logic             ld_wr_ok,
  input  logic             ld_present,
  input  logic             req_valid,
  input  logic [SEL_W-1:0] req_sel,
  input  logic [LEN_W-1:0] req_ofs,
  input  logic             req_write,
  output logic             rsp_valid,
  output logic [1:0]       rsp_cause,
  output logic [PA_W-1:0]  rsp_addr
);
  logic [IDX_W-1:0] req_idx;
  desc_t            ld_desc, cur_desc;
  cause_e           nxt_cause;
  logic [PA_W-1:0]  nxt_addr;
  // named events for the checker
  logic             hit_present, hit_over, hit_rdonly;

  assign ld_desc = '{base: ld_base, limit: ld_limit, wr_ok: ld_wr_ok, present: ld_present};

  xlate_sel_decode #(.SEL_W(SEL_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_dec (
    .sel (req_sel),
    .idx (req_idx)
  );

  xlate_desc_table #(.N_DESC(N_DESC)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ld_en),
    .wr_idx  (ld_idx),
    .wr_desc (ld_desc),
    .rd_idx  (req_idx),
    .rd_desc (cur_desc)
  );

  xlate_check u_chk_logic (
    .d           (cur_desc),
    .ofs         (req_ofs),
    .wr          (req_write),
    .cause       (nxt_cause),
    .addr        (nxt_addr),
    .hit_present (hit_present),
    .hit_over    (hit_over),
    .hit_rdonly  (hit_rdonly)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_cause <= CAUSE_NONE;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_cause <= nxt_cause;
        rsp_addr  <= (nxt_cause == CAUSE_NONE) ? nxt_addr : '0;
      end else begin
        rsp_cause <= CAUSE_NONE;
        rsp_addr  <= '0;
      end
    end
  end
endmodule

// File: rtl/xlate_chk.sv
module xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic        hit_present,
  input logic        hit_over,
  input logic        hit_rdonly,
  input logic        rsp_valid,
  input logic [1:0]  rsp_cause,
  input logic [23:0] rsp_addr
);
  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_cause == 2'b00 && rsp_addr == '0));

  // R4 R7
  absent_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit_present) |=> (rsp_cause == 2'b01));

  // R5
  range_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit_present && hit_over) |=> (rsp_cause == 2'b10));

  // R6
  rdonly_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit_present && !hit_over && req_write && hit_rdonly) |=> (rsp_cause == 2'b11));

  // R6
  read_not_rdonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> (rsp_cause != 2'b11));

  // R7
  fault_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause != 2'b00) |-> (rsp_addr == '0));
endmodule

bind prot_xlate xlate_chk u_xlate_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .hit_present (hit_present),
  .hit_over    (hit_over),
  .hit_rdonly  (hit_rdonly),
  .rsp_valid   (rsp_valid),
  .rsp_cause   (rsp_cause),
  .rsp_addr    (rsp_addr)
);

// File: tb/test_prot_xlate.sv
`timescale 1ns/1ps
module test_prot_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_idx = '0;
  logic [23:0] ld_base = '0;
  logic [15:0] ld_limit = '0;
  logic        ld_wr_ok = 1'b0, ld_present = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_sel = '0, req_ofs = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic [1:0]  rsp_cause;
  logic [23:0] rsp_addr;

  always #2 clk = ~clk; // 250 MHz

  prot_xlate i_prot_xlate (.*);

  // behavioural reference table
  int m_base [8];
  int m_lim  [8];
  bit m_wr   [8];
  bit m_pr   [8];

  int    checks = 0, failures = 0;
  bit    e_valid = 0;
  int    e_cause = 0, e_addr = 0;
  string e_tag = "R1";

  task automatic check_out();
    checks++;
    if (rsp_valid !== e_valid || int'(rsp_cause) != e_cause || int'(rsp_addr) != e_addr) begin
      failures++;
      $display("FAIL %s: got valid=%0b cause=%0d addr=%06h, expected valid=%0b cause=%0d addr=%06h",
               e_tag, rsp_valid, rsp_cause, rsp_addr, e_valid, e_cause, e_addr);
    end
  endtask

  // one clock: compare previous response, drive new inputs, predict
  task automatic step(input bit ld, input int li, input int lb, input int ll,
                      input bit lw, input bit lp,
                      input bit rq, input int sel, input int ofs, input bit wr,
                      input string tag);
    int k;
    @(negedge clk);
    check_out();
    ld_en = ld; ld_idx = 3'(li); ld_base = 24'(lb); ld_limit = 16'(ll);
    ld_wr_ok = lw; ld_present = lp;
    req_valid = rq; req_sel = 16'(sel); req_ofs = 16'(ofs); req_write = wr;
    e_valid = rq; e_cause = 0; e_addr = 0; e_tag = tag;
    if (rq) begin
      k = (sel / 8) % 8;
      if (!m_pr[k])                 e_cause = 1;
      else if (ofs >= m_lim[k])     e_cause = 2;
      else if (wr && !m_wr[k])      e_cause = 3;
      else                          e_addr = (m_base[k] + ofs) % 16777216;
    end
    if (ld) begin
      m_base[li] = lb; m_lim[li] = ll; m_wr[li] = lw; m_pr[li] = lp;
    end
  endtask

  task automatic load(input int li, input int lb, input int ll, input bit lw, input bit lp);
    step(1, li, lb, ll, lw, lp, 0, 0, 0, 0, "R2");
  endtask

  task automatic ask(input int sel, input int ofs, input bit wr, input string tag);
    step(0, 0, 0, 0, 0, 0, 1, sel, ofs, wr, tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_base[i] = 0; m_lim[i] = 0; m_wr[i] = 0; m_pr[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset outputs, all entries absent
    idle("R1");
    ask(16'h0010, 16'h0000, 0, "R1");
    ask(16'h0038, 16'h0001, 1, "R1");
    // R9: load entry 2 while asking for it in the same cycle, then again
    step(1, 2, 24'h164400, 16'h2400, 0, 1, 1, 16'h0010, 16'h0100, 0, "R9");
    ask(16'h0010, 16'h0100, 0, "R9");
    // R3: base + offset example
    load(1, 24'h164400, 16'h3000, 1, 1);
    ask(16'h0008, 16'h2400, 0, "R3");
    ask(16'h0008, 16'h2400, 1, "R3");
    // R5: boundary of the block
    ask(16'h0010, 16'h2400, 0, "R5");
    ask(16'h0010, 16'h23FF, 0, "R5");
    // R6: write to read-only, read passes
    ask(16'h0010, 16'h0004, 1, "R6");
    ask(16'h0010, 16'h0004, 0, "R6");
    // R7: bounds beats write protection; absent beats both
    ask(16'h0010, 16'hFFFF, 1, "R7");
    load(3, 24'h000000, 16'h0000, 0, 0);
    ask(16'h0018, 16'h0000, 1, "R7");
    // R5: zero-length block
    load(6, 24'h001000, 16'h0000, 1, 1);
    ask(16'h0030, 16'h0000, 0, "R5");
    // R8: bits [2:0] and [15:6] ignored (0xFFD5 -> entry 2)
    ask(16'hFFD5, 16'h23FF, 0, "R8");
    ask(16'h0017, 16'h0010, 1, "R8");
    ask(16'h8048, 16'h2400, 0, "R8");
    // R10: wrap at 2^24
    load(5, 24'hFFFF00, 16'hFFFF, 1, 1);
    ask(16'h0028, 16'h0200, 1, "R10");
    // R2: gaps between requests
    idle("R2");
    idle("R2");
    // R9: reload entry 1 back-to-back with requests; others unchanged
    step(1, 1, 24'h200000, 16'h0100, 0, 1, 1, 16'h0008, 16'h0200, 1, "R9");
    ask(16'h0008, 16'h0200, 0, "R9");
    ask(16'h0008, 16'h00FF, 1, "R9");
    ask(16'h0028, 16'h0100, 0, "R9");
    // mixed sweep over entries with loads in between
    for (int n = 0; n < 64; n++) begin
      if (n % 9 == 4)
        step(1, n % 8, (n * 24'h03A5F1) % 16777216, (n * 977) % 65536, n[0], (n % 3) != 0,
             1, n * 8 + (n % 8), (n * 613) % 65536, n[1], "R3");
      else
        ask(n * 8 + 16'h0100 * (n % 5), (n * 613) % 65536, n[1], "R3");
    end
    idle("R2");
    idle("R2");
    @(negedge clk);
    check_out();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule